// File: doc/BRIEF.md
# FlexRay Frame Deframer and Field Extractor

This block sits behind a bit sampler on a FlexRay channel. The sampler reports the end of the transmission start sequence and then gives one strobe for each sampled bit. The deframer checks the first three raw bits. A frame start bit followed by a 1-then-0 byte marker opens a frame. Any other pattern is reported as a collision avoidance symbol, and the block returns to idle. Inside a frame, the deframer drops the two-bit marker that leads every header, payload and trailer byte. It walks the 40-bit header, latches its fields and emits the payload bytes one at a time. It then steps over the 24-bit trailer CRC and the two-bit frame end sequence, handles the optional dynamic trailing sequence, and counts the channel idle delimiter before it reports the frame as done.

A downstream CRC checker is fed every stripped frame bit in transmission order, with two window markers. One marks the span covered by the header CRC: sync flag through payload length. The other marks the span covered by the frame CRC: the whole header and the payload. This block does no CRC arithmetic. It also raises a warning when the header breaks a consistency rule, and it keeps parsing the frame.

Control is one state machine with these states:
- IDLE: waits for the start strobe.
- START: checks the three raw start bits.
- HEADER: collects 40 header bits.
- PAYLOAD: collects 2 × length bytes.
- TRAILER: steps over 24 CRC bits.
- FES: steps over the two end bits.
- DTS_CHK: reads one bit to tell a static frame from a dynamic one.
- DTS_WAIT: waits for the line to go high.
- CID: counts the idle delimiter bits.

The transitions are:
- IDLE→START on the start strobe.
- START→HEADER on pattern 110.
- START→IDLE on any other pattern.
- HEADER→PAYLOAD, or HEADER→TRAILER when the length is 0.
- PAYLOAD→TRAILER after the last byte.
- TRAILER→FES.
- FES→DTS_CHK.
- DTS_CHK→CID on a 1, or DTS_CHK→DTS_WAIT on a 0.
- DTS_WAIT→CID on a 1.
- CID→IDLE after the 11th delimiter bit.

Top module: `fr_deframer`

## Requirements
- R1: After the start strobe, the first three raw bits 1,1,0 open a frame. Any other triple gives a one-cycle `cas_seen` pulse and a return to idle with no header strobe.
- R2: Two raw bits lead each header, payload and trailer byte, and they are dropped. The frame end bits and every later bit are taken as they are, with no marker removed.
- R3: The 40 header bits are taken in this order: reserved, preamble, data flag (0 = null frame), sync, startup, 11-bit ID, 7-bit length, 11-bit header CRC, 6-bit cycle. Multi-bit fields arrive MSB first. `hdr_vld` pulses once when the last header bit has been latched.
- R4: The payload is 2 × length bytes, each sent MSB first. `pay_vld` pulses once per byte, with the byte on `pay_byte`. A length of 0 gives no byte strobe.
- R5: After the payload come 24 trailer bits and 2 frame end bits. A 0 in the next bit sets `frm_dynamic`, and the block then waits for a 1 before the delimiter. A 1 in that bit counts as the first delimiter bit.
- R6: `frm_done` pulses only after the 11th delimiter bit, and the block is then idle. Bits that arrive while idle produce no strobe.
- R7: `proto_warn` is set together with `hdr_vld` when any of these holds: the ID is 0, startup is 1 while sync is 0, or a null frame has its preamble flag at 1. Parsing goes on. The flag holds until the next start strobe.
- R8: `crc_bit_vld` pulses once per stripped bit of the header, payload and trailer. `crc_hdr_win` marks exactly the 20 bits from sync through length. `crc_frm_win` marks the header and payload bits, and neither window marks a trailer bit.
- R9: After reset, every strobe and flag output is 0.
- R10: The header field outputs hold their values until the next header completes, including across a collision avoidance symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tss_seen | input | 1 | Start sequence ended; bits follow |
| bit_vld | input | 1 | One sampled bit is present |
| bit_val | input | 1 | Value of the sampled bit |
| hdr_vld | output | 1 | Header fields just latched |
| frm_reserved | output | 1 | Reserved header bit |
| frm_preamble | output | 1 | Payload preamble flag |
| frm_data | output | 1 | Data flag, 0 = null frame |
| frm_sync | output | 1 | Sync flag |
| frm_startup | output | 1 | Startup flag |
| frm_id | output | 11 | Frame ID |
| frm_len | output | 7 | Payload length in 2-byte words |
| frm_hcrc | output | 11 | Header CRC field |
| frm_cycle | output | 6 | Cycle count |
| proto_warn | output | 1 | Header consistency warning |
| pay_vld | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Payload byte |
| frm_dynamic | output | 1 | Dynamic trailing sequence seen |
| frm_done | output | 1 | Idle delimiter complete |
| cas_seen | output | 1 | Collision avoidance symbol |
| crc_bit_vld | output | 1 | Frame bit strobe for the CRC checker |
| crc_bit | output | 1 | Frame bit value |
| crc_hdr_win | output | 1 | Bit is covered by the header CRC |
| crc_frm_win | output | 1 | Bit is covered by the frame CRC |

## Verification
Random frames mix payload lengths, flag combinations, static and dynamic endings, different counts of low bits before the dynamic trailing sequence ends, and random idle gaps between bits. This tells apart designs that miscount the byte markers, the payload length or the delimiter. Directed frames cover the cases that separate one behaviour from another:
- a length of 0, which skips the payload;
- the largest length;
- each of the three warning conditions;
- start triples 1,1,1 and 0,1,0, which must be reported as collision symbols.

After a collision symbol, stray bits are sent while the block is idle to show they have no effect. The held header fields are then compared with those of the last frame, and the warning is checked to have cleared. The header CRC window is compared bit for bit with the expected sync-to-length span, which exposes a window shifted by one bit.

// File: rtl/fr_deframer_pkg.sv
package fr_deframer_pkg;

    // Parser states, in the order a frame visits them
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_HEADER,
        ST_PAYLOAD,
        ST_TRAILER,
        ST_FES,
        ST_DTS_CHK,
        ST_DTS_WAIT,
        ST_CID
    } fr_state_e;

    // Single-bit header flags ahead of the frame ID
    localparam int FLAG_BITS = 5;
    // Raw start triple that opens a frame
    localparam logic [2:0] START_PATTERN = 3'b110;

endpackage

// File: rtl/fr_bss_strip.sv
module fr_bss_strip #(
    parameter int BYTE_W = 8,
    parameter int BSS_W  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    input  logic bit_vld,
    input  logic bit_val,
    output logic dat_vld,
    output logic dat_bit
);
    localparam int GRP  = BYTE_W + BSS_W;
    localparam int PH_W = $clog2(GRP);

    logic [PH_W-1:0] phase_q;

    // Phase 0..BSS_W-1 are marker bits; the rest carry data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (load) begin
            phase_q <= PH_W'(BSS_W);
        end else if (en && bit_vld) begin
            phase_q <= (phase_q == PH_W'(GRP - 1)) ? '0 : phase_q + 1'b1;
        end
    end

    assign dat_vld = en && bit_vld && (phase_q >= PH_W'(BSS_W));
    assign dat_bit = bit_val;

endmodule

// File: rtl/fr_hdr_fields.sv
module fr_hdr_fields
    import fr_deframer_pkg::*;
#(
    parameter int ID_W   = 11,
    parameter int LEN_W  = 7,
    parameter int HCRC_W = 11,
    parameter int CYC_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              last,
    input  logic              bit_val,
    output logic [LEN_W-1:0]  len_now,
    output logic              hdr_vld,
    output logic              f_reserved,
    output logic              f_preamble,
    output logic              f_data,
    output logic              f_sync,
    output logic              f_startup,
    output logic [ID_W-1:0]   f_id,
    output logic [LEN_W-1:0]  f_len,
    output logic [HCRC_W-1:0] f_hcrc,
    output logic [CYC_W-1:0]  f_cycle,
    output logic              warn
);
    localparam int HDR_BITS = FLAG_BITS + ID_W + LEN_W + HCRC_W + CYC_W;
    localparam int P_RES    = HDR_BITS - 1;
    localparam int P_PPI    = HDR_BITS - 2;
    localparam int P_NF     = HDR_BITS - 3;
    localparam int P_SYNC   = HDR_BITS - 4;
    localparam int P_STUP   = HDR_BITS - 5;
    localparam int ID_LSB   = HDR_BITS - FLAG_BITS - ID_W;
    localparam int LEN_LSB  = ID_LSB - LEN_W;
    localparam int HCRC_LSB = LEN_LSB - HCRC_W;
    localparam int CYC_LSB  = HCRC_LSB - CYC_W;

    logic [HDR_BITS-1:0] sreg_q;
    logic [HDR_BITS-1:0] full;
    logic                bad_id, bad_sync, bad_pre;

    // The header as it stands once the current bit is shifted in
    assign full    = {sreg_q[HDR_BITS-2:0], bit_val};
    assign len_now = full[LEN_LSB +: LEN_W];

    assign bad_id   = (full[ID_LSB +: ID_W] == '0);
    assign bad_sync = full[P_STUP] && !full[P_SYNC];
    assign bad_pre  = !full[P_NF] && full[P_PPI];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q     <= '0;
            hdr_vld    <= 1'b0;
            warn       <= 1'b0;
            f_reserved <= 1'b0;
            f_preamble <= 1'b0;
            f_data     <= 1'b0;
            f_sync     <= 1'b0;
            f_startup  <= 1'b0;
            f_id       <= '0;
            f_len      <= '0;
            f_hcrc     <= '0;
            f_cycle    <= '0;
        end else begin
            hdr_vld <= shift && last;
            if (clr) begin
                sreg_q <= '0;
                warn   <= 1'b0;
            end else if (shift) begin
                sreg_q <= full;
                if (last) begin
                    f_reserved <= full[P_RES];
                    f_preamble <= full[P_PPI];
                    f_data     <= full[P_NF];
                    f_sync     <= full[P_SYNC];
                    f_startup  <= full[P_STUP];
                    f_id       <= full[ID_LSB +: ID_W];
                    f_len      <= full[LEN_LSB +: LEN_W];
                    f_hcrc     <= full[HCRC_LSB +: HCRC_W];
                    f_cycle    <= full[CYC_LSB +: CYC_W];
                    warn       <= bad_id || bad_sync || bad_pre;
                end
            end
        end
    end

    // R7: the warning only rises together with the header strobe
    a_r7_warn_at_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn) |-> hdr_vld);

endmodule

// File: rtl/fr_deframer.sv
module fr_deframer
    import fr_deframer_pkg::*;
#(
    parameter int ID_W      = 11,
    parameter int LEN_W     = 7,
    parameter int HCRC_W    = 11,
    parameter int CYC_W     = 6,
    parameter int BYTE_W    = 8,
    parameter int TCRC_BITS = 24,
    parameter int FES_BITS  = 2,
    parameter int CID_BITS  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tss_seen,
    input  logic              bit_vld,
    input  logic              bit_val,
    output logic              hdr_vld,
    output logic              frm_reserved,
    output logic              frm_preamble,
    output logic              frm_data,
    output logic              frm_sync,
    output logic              frm_startup,
    output logic [ID_W-1:0]   frm_id,
    output logic [LEN_W-1:0]  frm_len,
    output logic [HCRC_W-1:0] frm_hcrc,
    output logic [CYC_W-1:0]  frm_cycle,
    output logic              proto_warn,
    output logic              pay_vld,
    output logic [BYTE_W-1:0] pay_byte,
    output logic              frm_dynamic,
    output logic              frm_done,
    output logic              cas_seen,
    output logic              crc_bit_vld,
    output logic              crc_bit,
    output logic              crc_hdr_win,
    output logic              crc_frm_win
);
    localparam int HDR_BITS = FLAG_BITS + ID_W + LEN_W + HCRC_W + CYC_W;
    localparam int POS_W    = $clog2(HDR_BITS + TCRC_BITS + FES_BITS + CID_BITS + 4);
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int PCNT_W   = LEN_W + 1;
    localparam int HW_FIRST = 3;
    localparam int HW_LAST  = FLAG_BITS + ID_W + LEN_W - 1;

    fr_state_e         state_q, state_d;
    logic [POS_W-1:0]  pos_q;
    logic [1:0]        pat_q;
    logic [BIT_W-1:0]  pay_bit_q;
    logic [PCNT_W-1:0] pay_cnt_q;
    logic [BYTE_W-1:0] pay_sh_q;
    logic              dvld, dbit, strip_en, strip_load, hdr_shift, hdr_last;
    logic              start_ok, byte_end, pay_last;
    logic [LEN_W-1:0]  len_now;

    assign strip_en   = (state_q == ST_HEADER) || (state_q == ST_PAYLOAD) ||
                        (state_q == ST_TRAILER);
    assign strip_load = (state_q == ST_START) && bit_vld && (pos_q == POS_W'(2));
    assign start_ok   = ({pat_q, bit_val} == START_PATTERN);
    assign hdr_shift  = dvld && (state_q == ST_HEADER);
    assign hdr_last   = (pos_q == POS_W'(HDR_BITS - 1));
    assign byte_end   = (pay_bit_q == BIT_W'(BYTE_W - 1));
    assign pay_last   = byte_end && (PCNT_W'(pay_cnt_q + 1'b1) == {frm_len, 1'b0});

    fr_bss_strip #(.BYTE_W(BYTE_W), .BSS_W(2)) strip_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (strip_load),
        .en      (strip_en),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .dat_vld (dvld),
        .dat_bit (dbit)
    );

    fr_hdr_fields #(.ID_W(ID_W), .LEN_W(LEN_W), .HCRC_W(HCRC_W), .CYC_W(CYC_W)) hdr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        ((state_q == ST_IDLE) && tss_seen),
        .shift      (hdr_shift),
        .last       (hdr_last),
        .bit_val    (dbit),
        .len_now    (len_now),
        .hdr_vld    (hdr_vld),
        .f_reserved (frm_reserved),
        .f_preamble (frm_preamble),
        .f_data     (frm_data),
        .f_sync     (frm_sync),
        .f_startup  (frm_startup),
        .f_id       (frm_id),
        .f_len      (frm_len),
        .f_hcrc     (frm_hcrc),
        .f_cycle    (frm_cycle),
        .warn       (proto_warn)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (tss_seen) state_d = ST_START;
            ST_START:    if (strip_load) state_d = start_ok ? ST_HEADER : ST_IDLE;
            ST_HEADER:   if (dvld && hdr_last)
                             state_d = (len_now == '0) ? ST_TRAILER : ST_PAYLOAD;
            ST_PAYLOAD:  if (dvld && pay_last) state_d = ST_TRAILER;
            ST_TRAILER:  if (dvld && pos_q == POS_W'(TCRC_BITS - 1)) state_d = ST_FES;
            ST_FES:      if (bit_vld && pos_q == POS_W'(FES_BITS - 1)) state_d = ST_DTS_CHK;
            ST_DTS_CHK:  if (bit_vld) state_d = bit_val ? ST_CID : ST_DTS_WAIT;
            ST_DTS_WAIT: if (bit_vld && bit_val) state_d = ST_CID;
            ST_CID:      if (bit_vld && pos_q == POS_W'(CID_BITS - 1)) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counters and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q       <= '0;
            pat_q       <= '0;
            pay_bit_q   <= '0;
            pay_cnt_q   <= '0;
            pay_sh_q    <= '0;
            pay_vld     <= 1'b0;
            pay_byte    <= '0;
            frm_dynamic <= 1'b0;
            frm_done    <= 1'b0;
            cas_seen    <= 1'b0;
            crc_bit_vld <= 1'b0;
            crc_bit     <= 1'b0;
            crc_hdr_win <= 1'b0;
            crc_frm_win <= 1'b0;
        end else begin
            pay_vld     <= 1'b0;
            frm_done    <= 1'b0;
            cas_seen    <= 1'b0;
            crc_bit_vld <= 1'b0;

            // Position within the current state
            if (state_d != state_q) begin
                pos_q <= (state_q == ST_DTS_CHK) ? POS_W'(1) : '0;
            end else if (((state_q == ST_HEADER || state_q == ST_TRAILER) && dvld) ||
                         ((state_q == ST_START || state_q == ST_FES ||
                           state_q == ST_CID) && bit_vld)) begin
                pos_q <= pos_q + 1'b1;
            end

            if (state_q == ST_START && bit_vld) pat_q <= {pat_q[0], bit_val};
            if (strip_load && !start_ok) cas_seen <= 1'b1;

            // CRC checker feed
            if (dvld) begin
                crc_bit_vld <= 1'b1;
                crc_bit     <= dbit;
                crc_hdr_win <= (state_q == ST_HEADER) && (pos_q >= POS_W'(HW_FIRST)) &&
                               (pos_q <= POS_W'(HW_LAST));
                crc_frm_win <= (state_q != ST_TRAILER);
            end

            // Payload assembly
            if (state_q == ST_HEADER) begin
                pay_bit_q <= '0;
                pay_cnt_q <= '0;
            end else if (state_q == ST_PAYLOAD && dvld) begin
                pay_sh_q  <= {pay_sh_q[BYTE_W-2:0], dbit};
                pay_bit_q <= byte_end ? '0 : pay_bit_q + 1'b1;
                if (byte_end) begin
                    pay_byte  <= {pay_sh_q[BYTE_W-2:0], dbit};
                    pay_vld   <= 1'b1;
                    pay_cnt_q <= pay_cnt_q + 1'b1;
                end
            end

            if (state_q == ST_IDLE && tss_seen) frm_dynamic <= 1'b0;
            else if (state_q == ST_DTS_CHK && bit_vld && !bit_val) frm_dynamic <= 1'b1;

            if (state_q == ST_CID && state_d == ST_IDLE) frm_done <= 1'b1;
        end
    end

    // R1: a collision symbol leaves the parser idle
    a_r1_cas_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cas_seen |-> state_q == ST_IDLE);
    // R6: frame completion leaves the parser idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> state_q == ST_IDLE);
    // R4: never more bytes than the length field allows
    a_r4_pay_limit: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld |-> pay_cnt_q <= {frm_len, 1'b0});
    // R3: event strobes never coincide
    a_r3_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_vld, pay_vld, frm_done, cas_seen}));
    // R5: the dynamic flag rises only on entry to the trailing-sequence wait
    a_r5_dyn_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_dynamic) |-> state_q == ST_DTS_WAIT);

endmodule

// File: tb/fr_deframer_tb_top.sv
module fr_deframer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tss_seen = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_val = 1'b0;
    logic hdr_vld, frm_reserved, frm_preamble, frm_data, frm_sync, frm_startup;
    logic [10:0] frm_id;
    logic [6:0]  frm_len;
    logic [10:0] frm_hcrc;
    logic [5:0]  frm_cycle;
    logic proto_warn, pay_vld, frm_dynamic, frm_done, cas_seen;
    logic [7:0] pay_byte;
    logic crc_bit_vld, crc_bit, crc_hdr_win, crc_frm_win;

    always #(CLK_PERIOD/2) clk = ~clk;

    fr_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .tss_seen(tss_seen), .bit_vld(bit_vld), .bit_val(bit_val),
        .hdr_vld(hdr_vld), .frm_reserved(frm_reserved), .frm_preamble(frm_preamble),
        .frm_data(frm_data), .frm_sync(frm_sync), .frm_startup(frm_startup),
        .frm_id(frm_id), .frm_len(frm_len), .frm_hcrc(frm_hcrc), .frm_cycle(frm_cycle),
        .proto_warn(proto_warn), .pay_vld(pay_vld), .pay_byte(pay_byte),
        .frm_dynamic(frm_dynamic), .frm_done(frm_done), .cas_seen(cas_seen),
        .crc_bit_vld(crc_bit_vld), .crc_bit(crc_bit), .crc_hdr_win(crc_hdr_win),
        .crc_frm_win(crc_frm_win)
    );

    int nchk = 0;
    int nbad = 0;
    bit finished = 0;

    // Event monitor, counting only
    int hdr_n = 0, pay_n = 0, done_n = 0, cas_n = 0;
    int crc_n = 0, crc_h = 0, crc_f = 0;
    logic [19:0] hwin_sr = '0;
    logic [7:0] got_b [0:2047];
    always @(negedge clk) begin
        if (hdr_vld) hdr_n++;
        if (pay_vld) begin
            got_b[pay_n] = pay_byte;
            pay_n++;
        end
        if (frm_done) done_n++;
        if (cas_seen) cas_n++;
        if (crc_bit_vld) begin
            crc_n++;
            if (crc_hdr_win) begin
                crc_h++;
                hwin_sr = {hwin_sr[18:0], crc_bit};
            end
            if (crc_frm_win) crc_f++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    logic rb [0:4095];
    int   rn;
    logic [7:0] exp_b [0:255];

    function automatic void push(input logic b);
        rb[rn] = b;
        rn++;
    endfunction

    function automatic void push_byte(input logic [7:0] v);
        push(1'b1);
        push(1'b0);
        for (int i = 7; i >= 0; i--) push(v[i]);
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_vld = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic send_tss();
        @(negedge clk);
        tss_seen = 1'b1;
        @(negedge clk);
        tss_seen = 1'b0;
    endtask

    function automatic logic exp_warn(input logic ppi, input logic nf, input logic sy,
                                      input logic su, input logic [10:0] id);
        return (id == 0) || (su && !sy) || (!nf && ppi);
    endfunction

    task automatic run_frame(input logic res, input logic ppi, input logic nf,
                             input logic sy, input logic su, input logic [10:0] id,
                             input logic [6:0] len, input logic [10:0] hc,
                             input logic [5:0] cyc, input bit dyn, input int dz);
        logic [39:0] h;
        logic [23:0] tc;
        int h0, p0, d0, c0, n0, hh0, f0;
        h  = {res, ppi, nf, sy, su, id, len, hc, cyc};
        tc = 24'($urandom);
        rn = 0;
        push(1'b1);
        for (int k = 4; k >= 0; k--) push_byte(h[k*8 +: 8]);
        for (int k = 0; k < 2*len; k++) begin
            exp_b[k] = 8'($urandom);
            push_byte(exp_b[k]);
        end
        for (int k = 2; k >= 0; k--) push_byte(tc[k*8 +: 8]);
        push(1'b1);
        push(1'b0);
        if (dyn) begin
            push(1'b0);
            for (int k = 0; k < dz; k++) push(1'b0);
            push(1'b1);
        end
        for (int k = 0; k < 11; k++) push(1'b1);

        h0 = hdr_n; p0 = pay_n; d0 = done_n; c0 = cas_n;
        n0 = crc_n; hh0 = crc_h; f0 = crc_f;
        send_tss();
        for (int k = 0; k < rn - 1; k++) send_bit(rb[k]);
        #1;
        chk("R6 no done before last delimiter bit", 64'(done_n - d0), 64'd0);
        send_bit(rb[rn-1]);
        @(negedge clk);
        #1;
        chk("R6 done after delimiter", 64'(done_n - d0), 64'd1);
        chk("R1 no CAS for 110", 64'(cas_n - c0), 64'd0);
        chk("R3 header strobe", 64'(hdr_n - h0), 64'd1);
        chk("R3 header fields",
            64'({frm_reserved, frm_preamble, frm_data, frm_sync, frm_startup,
                 frm_id, frm_len, frm_hcrc, frm_cycle}), 64'(h));
        chk("R7 warning", 64'(proto_warn), 64'(exp_warn(ppi, nf, sy, su, id)));
        chk("R4 byte count", 64'(pay_n - p0), 64'(2*len));
        for (int k = 0; k < 2*len; k++)
            if (got_b[p0 + k] !== exp_b[k]) chk("R2 R4 byte value", 64'(got_b[p0+k]), 64'(exp_b[k]));
        nchk++;
        chk("R5 dynamic flag", 64'(frm_dynamic), 64'(dyn));
        chk("R8 crc bit count", 64'(crc_n - n0), 64'(40 + 16*len + 24));
        chk("R8 frame window count", 64'(crc_f - f0), 64'(40 + 16*len));
        chk("R8 header window count", 64'(crc_h - hh0), 64'd20);
        chk("R8 header window bits", 64'(hwin_sr), 64'(h[36:17]));
    endtask

    task automatic run_cas(input logic a, input logic b, input logic c);
        logic [39:0] held;
        int h0, c0, p0;
        held = {frm_reserved, frm_preamble, frm_data, frm_sync, frm_startup,
                frm_id, frm_len, frm_hcrc, frm_cycle};
        h0 = hdr_n; c0 = cas_n; p0 = pay_n;
        send_tss();
        send_bit(a);
        send_bit(b);
        send_bit(c);
        @(negedge clk);
        #1;
        chk("R1 CAS pulse", 64'(cas_n - c0), 64'd1);
        chk("R1 no header after CAS", 64'(hdr_n - h0), 64'd0);
        chk("R7 warning cleared at start", 64'(proto_warn), 64'd0);
        // stray bits while idle
        for (int k = 0; k < 60; k++) send_bit(1'(k % 3 == 0));
        #1;
        chk("R6 idle bits ignored", 64'({hdr_n - h0, pay_n - p0, cas_n - c0 - 1}), 64'd0);
        chk("R10 fields held", 64'({frm_reserved, frm_preamble, frm_data, frm_sync,
            frm_startup, frm_id, frm_len, frm_hcrc, frm_cycle}), 64'(held));
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset strobes",
            64'({hdr_vld, pay_vld, frm_done, cas_seen, crc_bit_vld, proto_warn, frm_dynamic}),
            64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R9 after reset", 64'({hdr_vld, pay_vld, frm_done, cas_seen, proto_warn}), 64'd0);

        // directed corner cases
        run_frame(0, 0, 1, 1, 1, 11'h2A5, 7'd0, 11'h3C1, 6'd5, 0, 0);
        run_frame(0, 1, 1, 0, 0, 11'h001, 7'd3, 11'h155, 6'd63, 1, 0);
        run_frame(0, 0, 1, 1, 0, 11'h000, 7'd1, 11'h0AA, 6'd0, 0, 0);
        run_cas(1, 1, 1);
        run_frame(1, 0, 1, 0, 1, 11'h7FF, 7'd2, 11'h7FF, 6'd17, 1, 5);
        run_frame(0, 1, 0, 1, 0, 11'h123, 7'd1, 11'h001, 6'd33, 0, 0);
        run_cas(0, 1, 0);
        run_frame(0, 0, 1, 1, 0, 11'h3FE, 7'd127, 11'h246, 6'd44, 0, 0);

        // random frames
        for (int r = 0; r < 10; r++) begin
            run_frame(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 11'($urandom), 7'($urandom_range(0, 12)),
                      11'($urandom), 6'($urandom), 1'($urandom), $urandom_range(0, 6));
        end
        summary();
    end

endmodule